// File: doc/BRIEF.md
# Polarity-Selectable Tri-State 1-of-32 Address Decoder

The block turns a 5-bit address into one selected line out of 32. It is built from four identical 8-line decoder slices. Each slice takes a 3-bit address, a polarity input, two active-low and two active-high gating enables, and two active-low output enables. The polarity input picks the active level. With polarity low, the selected line is driven high and the rest are low. With polarity high, the selected line is driven low and the rest are high. A gated-off slice holds all of its lines at the polarity level. A high on either output enable releases every line to high impedance.

The wrapper steers the slice gating enables from the two upper address bits, so exactly one slice decodes. It also feeds a global strobe pair into the gating enables that are left free. Because of this, the strobe can act as the data input of a 1-of-32 demultiplexer. Each line is available in two forms. One is a tri-state net. The other is a plain value vector paired with a drive-enable vector, for targets that have no internal tri-state buffers.

Top module: `addr_decoder32`

## Requirements
- R1: In a slice with both output enables low, both active-low gating enables low and both active-high gating enables high, exactly one of the eight lines differs from the polarity level. That line is the one whose index equals the 3-bit address (line 0 for address 0).
- R2: With the polarity input low and decoding active, the selected line is 1 and all other lines are 0.
- R3: With the polarity input high and decoding active, the selected line is 0 and all other lines are 1.
- R4: A 1 on either bit of `oe_n` clears every bit of the drive-enable vector, so all lines are high impedance. With both bits 0, every drive-enable bit is 1.
- R5: In a slice, a 1 on either active-low gating enable or a 0 on either active-high gating enable makes every line equal the polarity input, whatever the address.
- R6: In the wrapper, line index i (0 to 31) is the selected line exactly when `addr` equals i. Slice k drives lines 8k to 8k+7, and `addr[4:3]` chooses the slice.
- R7: In the wrapper, when `strobe_n` is 0 and `strobe` is 1, exactly one of the 32 lines is at the active level (the inverse of `pol`). When `strobe_n` is 1 or `strobe` is 0, all 32 lines equal `pol`.
- R8: Every bit of `line_o` whose drive-enable bit is 1 carries the same value as the matching bit of `line_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 5 | Line address; bits [4:3] pick the slice, bits [2:0] the line in the slice |
| pol | input | 1 | Polarity: 0 makes the selected line high, 1 makes it low |
| oe_n | input | 2 | Active-low output enables; a 1 on either bit floats all lines |
| strobe_n | input | 1 | Active-low global decode enable / demultiplexer data |
| strobe | input | 1 | Active-high global decode enable / demultiplexer data |
| line_o | output | 32 | Tri-state decoded lines |
| line_val | output | 32 | Logic value of each line, valid whether driven or not |
| line_drv | output | 32 | Drive enable per line; 1 where `line_o` is driven |

## Verification
The block has no stored state, so a wrong decode shows up at the ports in the same cycle the inputs change. A fault can appear in three ways. Two lines may leave the polarity level together. No line may leave it, even though the strobe pair is asserted. Or the drive-enable vector may disagree with `oe_n`. The bench compares every value of the 10 inputs of the top against a reference model, one combination per cycle. A separate slice instance is also compared across every value of its own 10 inputs. So a mismatch is reported on the very cycle it is driven.

// File: rtl/addr_decoder32.sv
module addr_slice #(
  parameter int AW = 3
) (
  input  logic [AW-1:0]       a,
  input  logic                pol,
  input  logic [1:0]          oe_n,
  input  logic [1:0]          en_n,
  input  logic [1:0]          en,
  output wire  [(1<<AW)-1:0]  y,
  output logic [(1<<AW)-1:0]  y_val,
  output logic [(1<<AW)-1:0]  y_drv
);
  localparam int N = 1 << AW;

  logic gate_ok;
  logic drive;

  assign gate_ok = ~|en_n & (&en);
  assign drive   = ~|oe_n;
  assign y_val   = {N{pol}} ^ (gate_ok ? (N'(1) << a) : N'(0));
  assign y_drv   = {N{drive}};

  for (genvar i = 0; i < N; i++) begin : g_buf
    assign y[i] = y_drv[i] ? y_val[i] : 1'bz;
  end

  always_comb begin
    if (gate_ok) begin
      assert_onehot_R1: assert ($countones(y_val ^ {N{pol}}) == 1)
        else $error("slice: not one-hot");
      if (!pol) begin
        assert_high_sel_R2: assert (y_val[a] == 1'b1)
          else $error("slice: selected line not high");
      end else begin
        assert_low_sel_R3: assert (y_val[a] == 1'b0)
          else $error("slice: selected line not low");
      end
    end else begin
      assert_gated_R5: assert (y_val == {N{pol}})
        else $error("slice: gated lines off polarity");
    end
    if (|oe_n) begin
      assert_float_R4: assert (y_drv == '0)
        else $error("slice: driven while disabled");
    end else begin
      assert_drive_R4: assert (y_drv == '1)
        else $error("slice: undriven while enabled");
    end
  end
endmodule

module addr_decoder32 #(
  parameter int SLICE_AW = 3
) (
  input  logic [SLICE_AW+1:0]            addr,
  input  logic                           pol,
  input  logic [1:0]                     oe_n,
  input  logic                           strobe_n,
  input  logic                           strobe,
  output wire  [(4<<SLICE_AW)-1:0]       line_o,
  output logic [(4<<SLICE_AW)-1:0]       line_val,
  output logic [(4<<SLICE_AW)-1:0]       line_drv
);
  localparam int NSL   = 4;
  localparam int SN    = 1 << SLICE_AW;
  localparam int LINES = NSL * SN;

  logic gate;
  assign gate = ~strobe_n & strobe;

  for (genvar k = 0; k < NSL; k++) begin : g_slice
    logic [1:0] sen_n;
    logic [1:0] sen;
    for (genvar b = 0; b < 2; b++) begin : g_bit
      if (((k >> b) & 1) == 1) begin : g_one
        assign sen[b]   = addr[SLICE_AW+b];
        assign sen_n[b] = (b == 0) ? strobe_n : ~strobe;
      end else begin : g_zero
        assign sen_n[b] = addr[SLICE_AW+b];
        assign sen[b]   = (b == 0) ? ~strobe_n : strobe;
      end
    end
    addr_slice #(.AW(SLICE_AW)) u_slice (
      .a     (addr[SLICE_AW-1:0]),
      .pol   (pol),
      .oe_n  (oe_n),
      .en_n  (sen_n),
      .en    (sen),
      .y     (line_o[k*SN +: SN]),
      .y_val (line_val[k*SN +: SN]),
      .y_drv (line_drv[k*SN +: SN])
    );
  end

  always_comb begin
    if (gate) begin
      assert_one_line_R7: assert ($countones(line_val ^ {LINES{pol}}) == 1)
        else $error("top: not exactly one active line");
      assert_pick_R6: assert (line_val[addr] == ~pol)
        else $error("top: wrong line selected");
    end else begin
      assert_idle_R7: assert (line_val == {LINES{pol}})
        else $error("top: line active while strobe off");
    end
  end
endmodule

// File: tb/tb_addr_decoder32.sv
module tb_addr_decoder32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  addr = '0;
  logic        pol = 1'b0;
  logic [1:0]  oe_n = 2'b11;
  logic        strobe_n = 1'b1;
  logic        strobe = 1'b0;
  wire  [31:0] line_o;
  logic [31:0] line_val, line_drv;

  logic [2:0]  s_a = '0;
  logic        s_pol = 1'b0;
  logic [1:0]  s_oe_n = 2'b11;
  logic [1:0]  s_en_n = 2'b11;
  logic [1:0]  s_en = 2'b00;
  wire  [7:0]  s_y;
  logic [7:0]  s_val, s_drv;

  addr_decoder32 dut (
    .addr(addr), .pol(pol), .oe_n(oe_n), .strobe_n(strobe_n), .strobe(strobe),
    .line_o(line_o), .line_val(line_val), .line_drv(line_drv)
  );

  addr_slice #(.AW(3)) slc (
    .a(s_a), .pol(s_pol), .oe_n(s_oe_n), .en_n(s_en_n), .en(s_en),
    .y(s_y), .y_val(s_val), .y_drv(s_drv)
  );

  typedef struct {
    bit          is_slice;
    logic [31:0] ev;
    logic [31:0] ed;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_slice(input int c);
    item_t it;
    logic act;
    {s_en, s_en_n, s_oe_n, s_pol, s_a} = c[9:0];
    act = (s_en_n == 2'b00) && (s_en == 2'b11);
    it.is_slice = 1;
    it.ev = {24'h0, {8{s_pol}} ^ (act ? (8'd1 << s_a) : 8'd0)};
    it.ed = {24'h0, (s_oe_n == 2'b00) ? 8'hff : 8'h00};
    if (s_oe_n != 2'b00) it.tag = "R4";
    else if (!act) it.tag = "R5";
    else it.tag = s_pol ? "R1 R3" : "R1 R2";
    q.push_back(it);
  endtask

  task automatic push_top(input int c);
    item_t it;
    logic g;
    {strobe, strobe_n, oe_n, pol, addr} = c[9:0];
    g = !strobe_n && strobe;
    it.is_slice = 0;
    it.ev = {32{pol}} ^ (g ? (32'd1 << addr) : 32'd0);
    it.ed = (oe_n == 2'b00) ? 32'hffff_ffff : 32'h0;
    if (oe_n != 2'b00) it.tag = "R4";
    else if (!g) it.tag = "R7";
    else it.tag = "R6 R7";
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.is_slice) begin
        check({it.tag, " slice value"}, {24'h0, s_val}, it.ev);
        check({it.tag, " slice drive"}, {24'h0, s_drv}, it.ed);
        check("R8 slice line", {24'h0, s_y & s_drv}, it.ev & it.ed);
      end else begin
        check({it.tag, " top value"}, line_val, it.ev);
        check({it.tag, " top drive"}, line_drv, it.ed);
        check("R8 top line", line_o & line_drv, it.ev & it.ed);
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    // idle state before stimulus: outputs released, lines parked at pol (R4, R7)
    #1;
    check("R4 idle drive", line_drv, 32'h0);
    check("R7 idle value", line_val, 32'h0);
    rst_n = 1'b1;
    // exhaustive slice sweep (R1 R2 R3 R4 R5)
    for (int c = 0; c < 1024; c++) begin
      @(posedge clk); #1;
      push_slice(c);
    end
    // exhaustive wrapper sweep (R4 R6 R7 R8)
    for (int c = 0; c < 1024; c++) begin
      @(posedge clk); #1;
      push_top(c);
    end
    @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule